// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status

This block takes one asynchronous serial line and turns it into characters for a host. It is timed by a clock enable that pulses sixteen times per bit period, and it never runs faster than that enable. The host picks the character shape while the line is idle. The length can be a full byte or one bit shorter. Parity can be odd, even or off. One or two stop bits can be selected.

Each finished character goes into a holding register and raises a ready flag. Four sticky status flags record line trouble: bad parity, a missing stop bit, a character lost because the host read too late, and a line held low for a whole character time. The host clears the ready flag with a data read strobe and clears the error flags with a separate status read strobe.

Top module: `serial_rx_lsr`

## Requirements
- R1: After reset, `ready_o`, `perr_o`, `ferr_o`, `oerr_o` and `brk_o` are 0, `data_o` is 0, and the line is taken as idle (high).
- R2: A low on the line starts a character only if it is still low at the 8th oversample tick. Otherwise the receiver goes back to idle and does not set `ready_o`.
- R3: Data bits arrive least significant bit first and are sampled in the middle of each bit. After the last checked stop bit, `data_o` holds the character and `ready_o` is 1.
- R4: With `cfg_len8_i`=1 a character has 8 data bits. With `cfg_len8_i`=0 it has 7 data bits and `data_o[7]` is 0.
- R5: `cfg_par_i` selects parity: 2'b01 is odd, 2'b10 is even, and 2'b00 or 2'b11 is none. With parity on, a parity bit follows the data and `perr_o` is set if the data bits and the parity bit together do not have the selected sense. With parity off, no parity bit is expected and `perr_o` is never set.
- R6: `cfg_stop2_i`=0 checks one stop bit and `cfg_stop2_i`=1 checks two. A low in any checked stop bit sets `ferr_o`.
- R7: If a character completes while `ready_o` is still 1, `oerr_o` is set and `data_o` is replaced by the new character.
- R8: If every bit after the start bit is low, through the last stop bit, the receiver loads `data_o` with 0 and sets both `brk_o` and `ferr_o`. It then starts no new character until the line has gone high.
- R9: A pulse on `rd_data_i` clears `ready_o` and leaves the four error flags unchanged.
- R10: A pulse on `rd_stat_i` clears `perr_o`, `ferr_o`, `oerr_o` and `brk_o` and leaves `ready_o` unchanged.
- R11: The receiver advances only on cycles where `tick16_i` is 1. A frame sent while `tick16_i` is held at 0 produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversample enable, 16 pulses per bit |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_i | input | 2 | 01 odd, 10 even, 00/11 none |
| cfg_stop2_i | input | 1 | 1: two stop bits checked |
| rd_data_i | input | 1 | Data read strobe, clears ready |
| rd_stat_i | input | 1 | Status read strobe, clears error flags |
| data_o | output | 8 | Received character |
| ready_o | output | 1 | Character waiting |
| perr_o | output | 1 | Sticky parity error |
| ferr_o | output | 1 | Sticky framing error |
| oerr_o | output | 1 | Sticky overrun |
| brk_o | output | 1 | Sticky break |

## Verification
The line passes through a two-stage synchronizer. A character is sealed at the middle of its last stop bit, and the holding register and flags take it one cycle later. Results are therefore due about half a bit period, plus three cycles, after the final stop bit begins, which is before that stop bit ends. The bench sends each whole frame, lets the line idle for one further bit period, and only then compares outputs on the falling clock edge. After each read strobe the bench checks the flags on the next falling edge, since they clear one edge after the strobe.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  parameter int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     len8_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  input  logic     stop2_i,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned BW    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BW-1:0]     bidx_q;
  logic [DATA_W-1:0] sr_q;
  logic              par_acc_q, perr_q, ferr_q, zero_q, stop_sec_q;
  logic              done_q;
  rx_char_t          char_q;

  logic [BW-1:0]     bidx_last;
  logic              bit_end, ferr_fin, zero_fin;
  logic [DATA_W-1:0] data_aligned;

  assign bidx_last    = len8_i ? BW'(DATA_W-1) : BW'(DATA_W-2);
  assign bit_end      = tick_i && (cnt_q == LAST);
  assign ferr_fin     = ferr_q | ~rx_i;
  assign zero_fin     = zero_q & ~rx_i;
  assign data_aligned = len8_i ? sr_q : (sr_q >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bidx_q     <= '0;
      sr_q       <= '0;
      par_acc_q  <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      zero_q     <= 1'b0;
      stop_sec_q <= 1'b0;
      done_q     <= 1'b0;
      char_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (rx_i) begin
                state_q <= ST_IDLE;  // glitch, not a start bit
              end else begin
                state_q    <= ST_DATA;
                bidx_q     <= '0;
                sr_q       <= '0;
                par_acc_q  <= 1'b0;
                perr_q     <= 1'b0;
                ferr_q     <= 1'b0;
                zero_q     <= 1'b1;
                stop_sec_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              sr_q      <= {rx_i, sr_q[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ rx_i;
              zero_q    <= zero_q & ~rx_i;
              bidx_q    <= bidx_q + 1'b1;
              if (bidx_q == bidx_last) state_q <= par_en_i ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              perr_q  <= (par_acc_q ^ rx_i) != par_odd_i;
              zero_q  <= zero_q & ~rx_i;
              state_q <= ST_STOP;
            end
          end
          ST_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              if (stop2_i && !stop_sec_q) begin
                stop_sec_q <= 1'b1;
                ferr_q     <= ferr_fin;
                zero_q     <= zero_fin;
              end else begin
                done_q      <= 1'b1;
                char_q.data <= zero_fin ? '0 : data_aligned;
                char_q.perr <= perr_q;
                char_q.ferr <= ferr_fin;
                char_q.brk  <= zero_fin;
                state_q     <= zero_fin ? ST_HOLD : ST_IDLE;
              end
            end
          end
          ST_HOLD: begin
            if (rx_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign char_o = char_q;

  // R11: no progress without the oversample enable
  a_r11_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q) && $stable(cnt_q));
  // R2: a high at mid start returns to idle
  a_r2_glitch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_START && cnt_q == MID && rx_i) |=> state_q == ST_IDLE);
  // R8: after a break no new start until the line is high
  a_r8_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !rx_i) |=> state_q == ST_HOLD);
endmodule

// File: rtl/rx_status.sv
module rx_status
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_char_t          char_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              oerr_o,
  output logic              brk_o
);
  logic [DATA_W-1:0] data_q;
  logic ready_q, perr_q, ferr_q, oerr_q, brk_q;
  logic lost;

  assign lost = done_i && ready_q && !rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      oerr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      if (done_i)         data_q  <= char_i.data;
      if (done_i)         ready_q <= 1'b1;
      else if (rd_data_i) ready_q <= 1'b0;
      // a new event wins over a clear in the same cycle
      perr_q <= (perr_q & ~rd_stat_i) | (done_i & char_i.perr);
      ferr_q <= (ferr_q & ~rd_stat_i) | (done_i & char_i.ferr);
      brk_q  <= (brk_q  & ~rd_stat_i) | (done_i & char_i.brk);
      oerr_q <= (oerr_q & ~rd_stat_i) | lost;
    end
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
  assign oerr_o  = oerr_q;
  assign brk_o   = brk_q;

  a_r3_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);
  a_r7_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_o && !rd_data_i) |=> oerr_o);
  a_r8_break_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && char_i.brk) |=> (data_o == '0) && brk_o && ferr_o);
  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !done_i) |=> !ready_o);
  a_r10_stat_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !rd_data_i && !done_i) |=> ready_o == $past(ready_o));
endmodule

// File: rtl/serial_rx_lsr.sv
module serial_rx_lsr
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rxd_i,
  input  logic              cfg_len8_i,
  input  logic [1:0]        cfg_par_i,
  input  logic              cfg_stop2_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              oerr_o,
  output logic              brk_o
);
  logic     rx_s, done;
  logic     par_en, par_odd;
  rx_char_t char_w;

  assign par_en  = cfg_par_i[0] ^ cfg_par_i[1];
  assign par_odd = cfg_par_i[0];

  rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  rx_frame #(.OSR(OSR)) i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .rx_i     (rx_s),
    .len8_i   (cfg_len8_i),
    .par_en_i (par_en),
    .par_odd_i(par_odd),
    .stop2_i  (cfg_stop2_i),
    .done_o   (done),
    .char_o   (char_w)
  );

  rx_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .char_i   (char_w),
    .rd_data_i(rd_data_i),
    .rd_stat_i(rd_stat_i),
    .data_o   (data_o),
    .ready_o  (ready_o),
    .perr_o   (perr_o),
    .ferr_o   (ferr_o),
    .oerr_o   (oerr_o),
    .brk_o    (brk_o)
  );
endmodule

// File: tb/test_serial_rx_lsr.sv
`timescale 1ns/1ps
module test_serial_rx_lsr;
  localparam int BIT = 16;

  typedef struct packed {
    logic [7:0] data;
    logic perr, ferr, oerr, brk;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, rxd = 1'b1;
  logic len8 = 1'b1, stop2 = 1'b0, rd_data = 1'b0, rd_stat = 1'b0;
  logic [1:0] par = 2'b00;
  logic [7:0] data;
  logic ready, perr, ferr, oerr, brk;
  int n_run = 0, n_fail = 0;
  bit finished = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  serial_rx_lsr i_serial_rx_lsr (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .cfg_len8_i(len8), .cfg_par_i(par), .cfg_stop2_i(stop2),
    .rd_data_i(rd_data), .rd_stat_i(rd_stat),
    .data_o(data), .ready_o(ready), .perr_o(perr), .ferr_o(ferr),
    .oerr_o(oerr), .brk_o(brk)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  // driver: sends one frame, pushes the expected result
  task automatic send(logic [7:0] d, bit bad_par, bit bad_stop, bit bad_stop2, bit push);
    int n = len8 ? 8 : 7;
    logic x = 1'b0;
    exp_t e;
    put_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      put_bit(d[i]);
      x ^= d[i];
    end
    if (par == 2'b01 || par == 2'b10) put_bit(((par == 2'b01) ? ~x : x) ^ bad_par);
    put_bit(~bad_stop);
    if (stop2) put_bit(~bad_stop2);
    put_bit(1'b1);
    e.data = len8 ? d : {1'b0, d[6:0]};
    e.perr = (par == 2'b01 || par == 2'b10) && bad_par;
    e.ferr = bad_stop || (stop2 && bad_stop2);
    e.oerr = 1'b0;
    e.brk  = 1'b0;
    if (push) q.push_back(e);
  endtask

  task automatic strobe(bit rdd, bit rds);
    rd_data = rdd; rd_stat = rds;
    @(negedge clk);
    rd_data = 0; rd_stat = 0;
    @(negedge clk);
  endtask

  // monitor: pops the oldest expectation, compares, then reads everything
  task automatic monitor(string req);
    exp_t e = q.pop_front();
    check({req, " ready"}, ready, 1);
    check({req, " data"}, data, e.data);
    check({req, " flags p/f/o/b"}, {perr, ferr, oerr, brk}, {e.perr, e.ferr, e.oerr, e.brk});
    strobe(1, 1);
    check({req, " cleared"}, {ready, perr, ferr, oerr, brk}, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset state", {data, ready, perr, ferr, oerr, brk}, 0);

    // R3 8N1, LSB first
    send(8'hA5, 0, 0, 0, 1); monitor("R3 8N1 A5");
    send(8'h3C, 0, 0, 0, 1); monitor("R3 8N1 3C");

    // R2 short low is ignored, receiver then still works
    rxd = 0; repeat (5) @(negedge clk); rxd = 1;
    repeat (3 * BIT) @(negedge clk);
    check("R2 glitch no ready", ready, 0);
    send(8'h81, 0, 0, 0, 1); monitor("R2 after glitch");

    // R4 7 data bits
    len8 = 0;
    send(8'hFF, 0, 0, 0, 1); monitor("R4 7-bit FF");
    len8 = 1;

    // R5 parity modes
    par = 2'b10; send(8'h07, 0, 0, 0, 1); monitor("R5 even ok");
    par = 2'b10; send(8'h07, 1, 0, 0, 1); monitor("R5 even bad");
    par = 2'b01; send(8'h5A, 0, 0, 0, 1); monitor("R5 odd ok");
    par = 2'b01; send(8'h5A, 1, 0, 0, 1); monitor("R5 odd bad");
    par = 2'b11; send(8'h12, 0, 0, 0, 1); monitor("R5 none");
    len8 = 0; par = 2'b01; send(8'h33, 1, 0, 0, 1); monitor("R5 7-bit odd bad");
    len8 = 1; par = 2'b00;

    // R6 stop bits
    send(8'hC3, 0, 1, 0, 1); monitor("R6 1 stop bad");
    stop2 = 1;
    send(8'h66, 0, 0, 0, 1); monitor("R6 2 stop ok");
    send(8'h66, 0, 0, 1, 1); monitor("R6 2nd stop bad");
    stop2 = 0;

    // R7 overrun: two characters, no read
    send(8'h11, 0, 0, 0, 0);
    send(8'h22, 0, 0, 0, 1);
    e = q.pop_front(); e.oerr = 1; q.push_front(e);
    monitor("R7 overrun");

    // R9 data read keeps error flags; R10 status read keeps ready
    par = 2'b10; send(8'h01, 1, 0, 0, 0); par = 2'b00;
    strobe(1, 0);
    check("R9 ready cleared", ready, 0);
    check("R9 perr kept", perr, 1);
    send(8'h44, 0, 0, 0, 0);
    strobe(0, 1);
    check("R10 flags cleared", {perr, ferr, oerr, brk}, 0);
    check("R10 ready kept", ready, 1);
    check("R10 data", data, 8'h44);
    strobe(1, 0);

    // R8 break: line low for 14 bit times
    rxd = 0; repeat (14 * BIT) @(negedge clk); rxd = 1;
    repeat (2 * BIT) @(negedge clk);
    e.data = 0; e.perr = 0; e.ferr = 1; e.oerr = 0; e.brk = 1;
    q.push_back(e);
    monitor("R8 break");
    repeat (2 * BIT) @(negedge clk);
    check("R8 single break char", ready, 0);

    // R11 no progress without tick
    tick = 0;
    send(8'h5A, 0, 0, 0, 0);
    check("R11 no char without tick", ready, 0);
    tick = 1;
    repeat (2 * BIT) @(negedge clk);
    check("R11 still idle", ready, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule